// File: doc/BRIEF.md
# Memory Streaming Port with Auto-Advancing Pointer

This block lets a host reach a byte-addressed external memory in bulk through a register bridge. The host first loads a 24-bit start pointer through three address registers. It then moves bytes through a single data register. Every byte written there lands at the pointer, and the pointer then steps forward by one. A typical use is loading a boot image of any length, for example at base 0x200000, as a series of sector-sized bursts. The pointer survives the end of each select window, so the host picks up where the previous burst stopped.

On the memory side the block talks to a 16-bit word memory through a request/ready interface. Byte pairs are packed high byte first and written as one word. A lone byte at either end of a run is written with a one-lane strobe. Word writes wait in a small FIFO while the memory is busy, and a sticky flag records any that were lost. Reads go through a one-word prefetch buffer. The first data read after the pointer is set returns a dummy byte and starts the fetch. After that, each consumed word triggers the fetch of the next, so the memory latency stays hidden behind the host's byte period.

Top module: `memstream_port`

## Requirements
- R1: Registers 0, 1 and 2 hold pointer bits 23:16, 15:8 and 7:0 respectively. A write to one of them replaces that byte of the pointer, and a read returns it.
- R2: A write to the data register (3) stores the byte at the pointer and then advances the pointer by one.
- R3: Memory words are 16 bits at word address = byte address / 2. The even byte travels on mem_wdata[15:8] with mem_be[1], the odd byte on mem_wdata[7:0] with mem_be[0]. An even byte followed by the odd byte of the same word is written as one request with mem_be = 2'b11. Every write request has a nonzero strobe, and every read request shows mem_be = 2'b11.
- R4: A byte written at an odd address with no pending even byte is written at once with mem_be = 2'b01. A pending even byte is not written until xfer_end pulses, an address register is written, or the data register is read. It is then written with mem_be = 2'b10, and its neighbour byte stays untouched.
- R5: The pointer and any pending byte survive an xfer_end pulse. Two bursts separated by xfer_end fill contiguous memory.
- R6: The first data-register read after reset, after an address write or after a data write returns 0x00 and leaves the pointer unchanged. Later data reads return the byte at the pointer and advance it.
- R7: With memory always ready, data reads spaced 4 clock cycles apart return consecutive bytes, across word boundaries and from an odd start, with no further dummy byte.
- R8: While mem_ready is low, up to FIFO_DEPTH word writes are held, and nothing reaches memory. They are written in order once mem_ready rises.
- R9: A word write that finds the FIFO full is dropped and sets status register 4 bit 0. That bit stays set until reset.
- R10: While mem_req is high and mem_ready is low, mem_req, mem_we, mem_addr, mem_wdata and mem_be hold their values into the next cycle.
- R11: After reset the pointer is 0, the status register reads 0, reg_rdata is 0 and mem_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | One-cycle register write strobe |
| reg_rd | input | 1 | One-cycle register read strobe |
| reg_addr | input | REG_AW | Register number |
| reg_wdata | input | 8 | Register write byte |
| reg_rdata | output | 8 | Byte returned by the last read, updated on the edge that takes reg_rd |
| xfer_end | input | 1 | Pulse when the host releases the select line |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W-1 | Word address |
| mem_wdata | output | 16 | Write word |
| mem_be | output | 2 | Byte lane strobe, bit 1 = even byte |
| mem_rdata | input | 16 | Read word, valid the cycle after an accepted read |
| mem_ready | input | 1 | Memory takes the request this cycle |

## Verification
Some properties hold on every cycle, and the assertions check those. They cover a stalled request holding its fields, the write strobe never being empty, the FIFO fill never exceeding its depth, the overflow flag staying set, and the pointer stepping once per data write while a dummy read leaves it still. The bench scenarios check what only a sequence of operations can show. That includes the byte contents landing in memory for even and odd starts and ends, and the pending byte staying unwritten until a flush event. It also covers bursts joined across xfer_end, the dummy read and a gap-free read stream across word boundaries, and which words survive a FIFO overflow.

// File: rtl/memstream_pkg.sv
package memstream_pkg;
   localparam int BYTE_W = 8;
   localparam int WORD_W = 16;
   localparam int LANES  = WORD_W / BYTE_W;
   typedef logic [LANES-1:0] lane_t;
   localparam lane_t LANE_HI   = 2'b10;
   localparam lane_t LANE_LO   = 2'b01;
   localparam lane_t LANE_BOTH = 2'b11;
endpackage

// File: rtl/memstream_fifo.sv
module memstream_fifo #(
   parameter int WIDTH = 41,
   parameter int DEPTH = 4,
   localparam int PW = $clog2(DEPTH),
   localparam int CW = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic             empty,
   output logic             full,
   output logic [CW-1:0]    count
);
   generate
      if (DEPTH < 4) begin : g_bad_depth
         $error("memstream_fifo: DEPTH must be at least 4");
      end
   endgenerate

   logic [WIDTH-1:0] store [DEPTH];
   logic [PW-1:0]    wp_q, rp_q;
   logic [CW-1:0]    cnt_q;
   logic             do_push, do_pop;

   assign empty   = (cnt_q == '0);
   assign full    = (cnt_q == CW'(DEPTH));
   assign count   = cnt_q;
   assign dout    = store[rp_q];
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;

   function automatic logic [PW-1:0] wrap_inc(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (do_push) store[wp_q] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp_q  <= '0;
         rp_q  <= '0;
         cnt_q <= '0;
      end else begin
         if (do_push) wp_q <= wrap_inc(wp_q);
         if (do_pop)  rp_q <= wrap_inc(rp_q);
         case ({do_push, do_pop})
            2'b10:   cnt_q <= cnt_q + CW'(1);
            2'b01:   cnt_q <= cnt_q - CW'(1);
            default: cnt_q <= cnt_q;
         endcase
      end
   end
endmodule

// File: rtl/memstream_pack.sv
module memstream_pack
   import memstream_pkg::*;
#(
   parameter int ADDR_W = 24,
   localparam int WAW = ADDR_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [BYTE_W-1:0] wr_byte,
   input  logic [ADDR_W-1:0] ptr,
   input  logic              flush,
   output logic              push,
   output logic [WAW-1:0]    push_waddr,
   output logic [WORD_W-1:0] push_data,
   output lane_t             push_be
);
   logic              hold_v_q;
   logic [BYTE_W-1:0] hold_b_q;
   logic [WAW-1:0]    hold_a_q;

   always_comb begin
      push       = 1'b0;
      push_waddr = ptr[ADDR_W-1:1];
      push_data  = '0;
      push_be    = LANE_BOTH;
      if (wr_en && ptr[0]) begin
         push      = 1'b1;
         push_data = {(hold_v_q ? hold_b_q : '0), wr_byte};
         push_be   = hold_v_q ? LANE_BOTH : LANE_LO;
      end else if (!wr_en && flush && hold_v_q) begin
         push       = 1'b1;
         push_waddr = hold_a_q;
         push_data  = {hold_b_q, {BYTE_W{1'b0}}};
         push_be    = LANE_HI;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v_q <= 1'b0;
         hold_b_q <= '0;
         hold_a_q <= '0;
      end else if (wr_en) begin
         if (!ptr[0]) begin
            hold_v_q <= 1'b1;
            hold_b_q <= wr_byte;
            hold_a_q <= ptr[ADDR_W-1:1];
         end else begin
            hold_v_q <= 1'b0;
         end
      end else if (flush) begin
         hold_v_q <= 1'b0;
      end
   end
endmodule

// File: rtl/memstream_prefetch.sv
module memstream_prefetch
   import memstream_pkg::*;
#(
   parameter int ADDR_W = 24,
   localparam int WAW = ADDR_W - 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              consume,
   input  logic              restart,
   input  logic [ADDR_W-1:0] ptr,
   input  logic              ack,
   input  logic [WORD_W-1:0] rdata,
   output logic              need,
   output logic [WAW-1:0]    need_waddr,
   output logic              valid,
   output logic [BYTE_W-1:0] rd_byte,
   output logic              advance
);
   logic              valid_q, need_q, infl_q, disc_q;
   logic [WORD_W-1:0] word_q;
   logic [WAW-1:0]    naddr_q;

   assign need       = need_q;
   assign need_waddr = naddr_q;
   assign valid      = valid_q;
   assign advance    = consume && valid_q;
   assign rd_byte    = !valid_q ? '0 :
                       (ptr[0] ? word_q[BYTE_W-1:0] : word_q[WORD_W-1:BYTE_W]);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         need_q  <= 1'b0;
         infl_q  <= 1'b0;
         disc_q  <= 1'b0;
         word_q  <= '0;
         naddr_q <= '0;
      end else begin
         infl_q <= ack;
         if (ack) need_q <= 1'b0;
         if (infl_q) begin
            if (!disc_q && !restart) begin
               valid_q <= 1'b1;
               word_q  <= rdata;
            end
            disc_q <= 1'b0;
         end
         if (consume) begin
            if (valid_q) begin
               if (ptr[0]) begin
                  valid_q <= 1'b0;
                  need_q  <= 1'b1;
                  naddr_q <= ptr[ADDR_W-1:1] + WAW'(1);
               end
            end else if (!need_q && !infl_q) begin
               need_q  <= 1'b1;
               naddr_q <= ptr[ADDR_W-1:1];
            end
         end
         if (restart) begin
            valid_q <= 1'b0;
            if (need_q) disc_q <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/memstream_port.sv
module memstream_port
   import memstream_pkg::*;
#(
   parameter int ADDR_W     = 24,
   parameter int FIFO_DEPTH = 4,
   parameter int REG_AW     = 3,
   localparam int WAW = ADDR_W - 1,
   localparam int NAB = ADDR_W / BYTE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_rd,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [7:0]        reg_wdata,
   output logic [7:0]        reg_rdata,
   input  logic              xfer_end,
   output logic              mem_req,
   output logic              mem_we,
   output logic [WAW-1:0]    mem_addr,
   output logic [15:0]       mem_wdata,
   output logic [1:0]        mem_be,
   input  logic [15:0]       mem_rdata,
   input  logic              mem_ready
);
   localparam int DATA_REG = NAB;
   localparam int STAT_REG = NAB + 1;
   localparam int EW       = WAW + WORD_W + LANES;
   localparam int CW       = $clog2(FIFO_DEPTH + 1);

   generate
      if ((ADDR_W % BYTE_W) != 0 || ADDR_W < 16) begin : g_bad_aw
         $error("memstream_port: ADDR_W must be a multiple of 8 and at least 16");
      end
      if ((1 << REG_AW) <= STAT_REG) begin : g_bad_raw
         $error("memstream_port: REG_AW too small for the register map");
      end
   endgenerate

   // register decode
   logic addr_wr, data_wr, data_rd, restart, flush;
   assign addr_wr = reg_wr && (reg_addr < REG_AW'(NAB));
   assign data_wr = reg_wr && (reg_addr == REG_AW'(DATA_REG));
   assign data_rd = reg_rd && (reg_addr == REG_AW'(DATA_REG));
   assign restart = addr_wr || data_wr;
   assign flush   = xfer_end || addr_wr || data_rd;

   logic [ADDR_W-1:0] ptr_q, ptr_wr_val;
   logic [7:0]        ptr_byte [NAB];
   logic              err_q;

   genvar g;
   generate
      for (g = 0; g < NAB; g++) begin : g_lane
         assign ptr_byte[g] = ptr_q[(NAB-1-g)*BYTE_W +: BYTE_W];
      end
   endgenerate

   always_comb begin
      ptr_wr_val = ptr_q;
      for (int i = 0; i < NAB; i++) begin
         if (reg_addr == REG_AW'(i)) ptr_wr_val[(NAB-1-i)*BYTE_W +: BYTE_W] = reg_wdata;
      end
   end

   // write packer and FIFO
   logic              pk_push;
   logic [WAW-1:0]    pk_waddr;
   logic [WORD_W-1:0] pk_data;
   lane_t             pk_be;

   memstream_pack #(.ADDR_W(ADDR_W)) u_pack (
      .clk(clk), .rst_n(rst_n), .wr_en(data_wr), .wr_byte(reg_wdata),
      .ptr(ptr_q), .flush(flush), .push(pk_push), .push_waddr(pk_waddr),
      .push_data(pk_data), .push_be(pk_be)
   );

   logic [EW-1:0]     f_dout;
   logic              f_empty, f_full, f_pop;
   logic [CW-1:0]     fifo_cnt;
   logic [WAW-1:0]    f_waddr;
   logic [WORD_W-1:0] f_data;
   lane_t             f_be;

   memstream_fifo #(.WIDTH(EW), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(pk_push), .din({pk_waddr, pk_data, pk_be}),
      .pop(f_pop), .dout(f_dout), .empty(f_empty), .full(f_full), .count(fifo_cnt)
   );
   assign {f_waddr, f_data, f_be} = f_dout;

   // read prefetch
   logic              pf_need, pf_valid, pf_adv, pf_ack;
   logic [WAW-1:0]    pf_waddr;
   logic [BYTE_W-1:0] pf_byte;

   memstream_prefetch #(.ADDR_W(ADDR_W)) u_pf (
      .clk(clk), .rst_n(rst_n), .consume(data_rd), .restart(restart),
      .ptr(ptr_q), .ack(pf_ack), .rdata(mem_rdata), .need(pf_need),
      .need_waddr(pf_waddr), .valid(pf_valid), .rd_byte(pf_byte), .advance(pf_adv)
   );

   // memory arbiter: writes first, a presented read stays until taken
   logic rd_lock_q, sel_rd, sel_wr;
   assign sel_rd    = pf_need && (rd_lock_q || f_empty);
   assign sel_wr    = !sel_rd && !f_empty;
   assign f_pop     = sel_wr && mem_ready;
   assign pf_ack    = sel_rd && mem_ready;
   assign mem_req   = sel_rd || sel_wr;
   assign mem_we    = sel_wr;
   assign mem_addr  = sel_wr ? f_waddr : pf_waddr;
   assign mem_wdata = sel_wr ? f_data : '0;
   assign mem_be    = sel_wr ? f_be : LANE_BOTH;

   // register read data
   logic [7:0] rd_nxt;
   always_comb begin
      rd_nxt = '0;
      for (int i = 0; i < NAB; i++) begin
         if (reg_addr == REG_AW'(i)) rd_nxt = ptr_byte[i];
      end
      if (reg_addr == REG_AW'(DATA_REG)) rd_nxt = pf_byte;
      if (reg_addr == REG_AW'(STAT_REG)) rd_nxt = {7'b0, err_q};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr_q     <= '0;
         err_q     <= 1'b0;
         rd_lock_q <= 1'b0;
         reg_rdata <= '0;
      end else begin
         if (addr_wr)                 ptr_q <= ptr_wr_val;
         else if (data_wr || pf_adv)  ptr_q <= ptr_q + ADDR_W'(1);
         if (pk_push && f_full)       err_q <= 1'b1;
         rd_lock_q <= sel_rd && !mem_ready;
         if (reg_rd)                  reg_rdata <= rd_nxt;
      end
   end
endmodule

// File: rtl/memstream_chk.sv
module memstream_chk #(
   parameter int ADDR_W     = 24,
   parameter int FIFO_DEPTH = 4,
   parameter int REG_AW     = 3,
   localparam int WAW = ADDR_W - 1,
   localparam int CW  = $clog2(FIFO_DEPTH + 1),
   localparam int DATA_REG = ADDR_W / 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_rd,
   input logic [REG_AW-1:0] reg_addr,
   input logic              mem_req,
   input logic              mem_we,
   input logic [WAW-1:0]    mem_addr,
   input logic [15:0]       mem_wdata,
   input logic [1:0]        mem_be,
   input logic              mem_ready,
   input logic              err_q,
   input logic [CW-1:0]     fifo_cnt,
   input logic [ADDR_W-1:0] ptr_q,
   input logic              pf_valid
);
   a_r10_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_ready |=> mem_req && $stable(mem_we) && $stable(mem_addr)
                                && $stable(mem_wdata) && $stable(mem_be));

   a_r3_wr_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && mem_we |-> mem_be != 2'b00);

   a_r3_rd_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req && !mem_we |-> mem_be == 2'b11);

   a_r8_fifo_bound: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_cnt <= CW'(FIFO_DEPTH));

   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      err_q |=> err_q);

   a_r2_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      reg_wr && reg_addr == REG_AW'(DATA_REG) |=> ptr_q == $past(ptr_q) + ADDR_W'(1));

   a_r6_dummy_hold: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rd && reg_addr == REG_AW'(DATA_REG) && !pf_valid && !reg_wr |=> $stable(ptr_q));
endmodule

bind memstream_port memstream_chk #(
   .ADDR_W(ADDR_W), .FIFO_DEPTH(FIFO_DEPTH), .REG_AW(REG_AW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
   .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
   .mem_be(mem_be), .mem_ready(mem_ready), .err_q(err_q), .fifo_cnt(fifo_cnt),
   .ptr_q(ptr_q), .pf_valid(pf_valid)
);

// File: tb/memstream_port_bench.sv
module memstream_port_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 5;
   // {start byte address, length}
   localparam logic [31:0] VEC [NV] = '{
      {24'h200000, 8'd8}, {24'h200011, 8'd6}, {24'h200020, 8'd1},
      {24'h200031, 8'd1}, {24'h200040, 8'd16}
   };

   logic        clk = 0, rst_n = 0;
   logic        reg_wr = 0, reg_rd = 0, xfer_end = 0, mem_ready = 1;
   logic [2:0]  reg_addr = 0;
   logic [7:0]  reg_wdata = 0, reg_rdata;
   logic        mem_req, mem_we;
   logic [22:0] mem_addr;
   logic [15:0] mem_wdata, mem_rdata;
   logic [1:0]  mem_be;
   logic [15:0] wmem [1024];
   int total = 0, bad = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   memstream_port u_memstream_port (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_end(xfer_end),
      .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_be(mem_be), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
   );

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 1024; i++) wmem[i] <= 16'hEEEE;
         mem_rdata <= 16'h0;
      end else if (mem_req && mem_ready) begin
         if (mem_we) begin
            if (mem_be[1]) wmem[mem_addr[9:0]][15:8] <= mem_wdata[15:8];
            if (mem_be[0]) wmem[mem_addr[9:0]][7:0]  <= mem_wdata[7:0];
         end else begin
            mem_rdata <= wmem[mem_addr[9:0]];
         end
      end
   end

   function automatic logic [7:0] mbyte(input logic [23:0] a);
      logic [15:0] w;
      w = wmem[a[10:1]];
      return a[0] ? w[7:0] : w[15:8];
   endfunction

   function automatic logic [7:0] pat(input int e, input int k);
      return 8'((e * 37 + k * 11 + 3) & 255);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic reg_write(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      reg_wr = 1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 0;
      idle(2);
   endtask

   task automatic reg_read(input logic [2:0] a, input int gap, output logic [7:0] d);
      @(negedge clk);
      reg_rd = 1; reg_addr = a;
      @(negedge clk);
      reg_rd = 0;
      d = reg_rdata;
      idle(gap);
   endtask

   task automatic set_addr(input logic [23:0] a);
      reg_write(3'd0, a[23:16]);
      reg_write(3'd1, a[15:8]);
      reg_write(3'd2, a[7:0]);
   endtask

   task automatic get_ptr(output logic [23:0] p);
      logic [7:0] b0, b1, b2;
      reg_read(3'd0, 1, b0);
      reg_read(3'd1, 1, b1);
      reg_read(3'd2, 1, b2);
      p = {b0, b1, b2};
   endtask

   task automatic end_xfer();
      @(negedge clk);
      xfer_end = 1;
      @(negedge clk);
      xfer_end = 0;
      idle(6);
   endtask

   task automatic summary();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog actual=%h expected=%h", 0, 1);
         summary();
      end
   end

   initial begin
      logic [23:0] p;
      logic [7:0]  d;
      logic [23:0] st;
      int          len;
      idle(5);
      rst_n = 1;
      idle(2);
      // R11 reset state
      chk(reg_rdata == 8'h00, "R11 rdata", 32'(reg_rdata), 0);
      chk(mem_req == 1'b0, "R11 mem_req", 32'(mem_req), 0);
      get_ptr(p);
      chk(p == 24'h0, "R11 ptr", 32'(p), 0);
      reg_read(3'd4, 1, d);
      chk(d == 8'h00, "R11 status", 32'(d), 0);

      // R1 pointer registers
      set_addr(24'h200000);
      get_ptr(p);
      chk(p == 24'h200000, "R1 ptr readback", 32'(p), 32'h200000);
      set_addr(24'h12AB3C);
      get_ptr(p);
      chk(p == 24'h12AB3C, "R1 ptr byte order", 32'(p), 32'h12AB3C);

      // R2 R3 R4 vector table
      for (int e = 0; e < NV; e++) begin
         st  = VEC[e][31:8];
         len = int'(VEC[e][7:0]);
         set_addr(st);
         for (int k = 0; k < len; k++) reg_write(3'd3, pat(e, k));
         end_xfer();
         for (int k = 0; k < len; k++) begin
            d = mbyte(st + 24'(k));
            chk(d == pat(e, k), "R2 R3 stored byte", 32'(d), 32'(pat(e, k)));
         end
         d = mbyte(st - 24'd1);
         if (e != 2) chk(d == 8'hEE || e == 4, "R4 byte below untouched", 32'(d), 32'hEE);
         d = mbyte(st + 24'(len));
         chk(d == 8'hEE, "R4 byte above untouched", 32'(d), 32'hEE);
         get_ptr(p);
         chk(p == st + 24'(len), "R2 ptr after run", 32'(p), 32'(st + 24'(len)));
      end

      // R4 pending even byte held until flush
      set_addr(24'h200060);
      reg_write(3'd3, 8'h5C);
      idle(6);
      d = mbyte(24'h200060);
      chk(d == 8'hEE, "R4 pending not written", 32'(d), 32'hEE);
      end_xfer();
      d = mbyte(24'h200060);
      chk(d == 8'h5C, "R4 flushed byte", 32'(d), 32'h5C);
      d = mbyte(24'h200061);
      chk(d == 8'hEE, "R4 neighbour lane", 32'(d), 32'hEE);

      // R5 bursts across xfer_end, split mid word
      set_addr(24'h200080);
      for (int k = 0; k < 3; k++) reg_write(3'd3, pat(9, k));
      end_xfer();
      for (int k = 3; k < 8; k++) reg_write(3'd3, pat(9, k));
      end_xfer();
      for (int k = 0; k < 8; k++) begin
         d = mbyte(24'h200080 + 24'(k));
         chk(d == pat(9, k), "R5 burst content", 32'(d), 32'(pat(9, k)));
      end
      get_ptr(p);
      chk(p == 24'h200088, "R5 ptr continues", 32'(p), 32'h200088);

      // R6 dummy then data
      set_addr(24'h200000);
      reg_read(3'd3, 6, d);
      chk(d == 8'h00, "R6 dummy byte", 32'(d), 0);
      get_ptr(p);
      chk(p == 24'h200000, "R6 dummy keeps ptr", 32'(p), 32'h200000);
      for (int k = 0; k < 8; k++) begin
         reg_read(3'd3, 6, d);
         chk(d == pat(0, k), "R6 read byte", 32'(d), 32'(pat(0, k)));
      end
      get_ptr(p);
      chk(p == 24'h200008, "R6 ptr after reads", 32'(p), 32'h200008);

      // R7 odd start, 4-cycle spacing
      set_addr(24'h200041);
      reg_read(3'd3, 3, d);
      chk(d == 8'h00, "R7 dummy byte", 32'(d), 0);
      for (int k = 1; k < 12; k++) begin
         reg_read(3'd3, 2, d);
         chk(d == pat(4, k), "R7 stream byte", 32'(d), 32'(pat(4, k)));
      end

      // R8 R9 stall and overflow
      @(negedge clk);
      mem_ready = 0;
      set_addr(24'h200100);
      for (int k = 0; k < 12; k++) reg_write(3'd3, pat(7, k));
      d = mbyte(24'h200100);
      chk(d == 8'hEE, "R8 nothing written while stalled", 32'(d), 32'hEE);
      reg_read(3'd4, 1, d);
      chk(d == 8'h01, "R9 overflow flag", 32'(d), 1);
      @(negedge clk);
      mem_ready = 1;
      idle(12);
      for (int k = 0; k < 8; k++) begin
         d = mbyte(24'h200100 + 24'(k));
         chk(d == pat(7, k), "R8 drained in order", 32'(d), 32'(pat(7, k)));
      end
      for (int k = 8; k < 12; k++) begin
         d = mbyte(24'h200100 + 24'(k));
         chk(d == 8'hEE, "R9 dropped word", 32'(d), 32'hEE);
      end
      reg_read(3'd4, 1, d);
      chk(d == 8'h01, "R9 flag sticky", 32'(d), 1);
      get_ptr(p);
      chk(p == 24'h20010C, "R9 ptr still advances", 32'(p), 32'h20010C);

      done = 1;
      summary();
   end
endmodule